// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Buffer

This block is the receive end of an isochronous OUT endpoint. A serial engine ahead of it has already decoded the bus and delivers the packet one byte at a time. A byte strobe carries each payload byte, and a separate end-of-packet strobe carries a CRC-good flag. The block writes the payload into on-chip bank storage. In single-bank mode every packet uses bank 0. In dual-bank mode packets alternate between bank 0 and bank 1, so the host can fill one bank while software drains the other.

Software sees the following:
- a received flag for each bank, which software clears with a one-cycle pulse;
- the byte count and read data of the bank chosen by a select input;
- a CRC-error bit that reflects the latest stored packet;
- an interrupt request, gated by an enable input.

Isochronous traffic has no handshake. The block therefore never pushes back on the host. Data that cannot be stored is dropped without notice.

The bench never asserts the byte strobe and the end-of-packet strobe in the same cycle.

Top module: `iso_out_rxbuf`

## Requirements
- R1: While `ep_enable` or `ep_configured` is low, byte and end-of-packet strobes change no flag, count or CRC status.
- R2: An end-of-packet strobe that reaches a bank whose flag is clear sets that bank's bit of `rx_flag` (bit 0 = bank 0, bit 1 = bank 1) one cycle later.
- R3: `byte_cnt` gives the number of bytes stored in the selected bank. A zero-length packet leaves it at 0. When the read pointer equals the count, `rd_data` reads 0.
- R4: `crc_err` takes the inverse of `rx_crc_ok` from each end-of-packet strobe that sets a flag. Packets that are discarded leave it unchanged.
- R5: While a bank's flag is set, bytes and end-of-packet strobes aimed at that bank are discarded. Its count, data and flag do not change.
- R6: A clear pulse on `sw_clear[b]` zeroes the flag, count and read pointer of bank b at the next edge. A byte in the same cycle as the pulse is dropped. Later bytes are stored from address 0.
- R7: Bytes beyond `DEPTH` are dropped and the count stays at `DEPTH`. The packet's end strobe still sets the flag.
- R8: With `pingpong` high, stored packets alternate bank 0, bank 1, bank 0 and so on. A packet that arrives while its target bank is full is discarded and does not advance the alternation.
- R9: `rd_data` shows the byte at the selected bank's read pointer. A `sw_read` pulse advances that pointer by one, up to the count. Bytes come out in arrival order.
- R10: `irq` is high exactly when `irq_enable` is high and at least one flag is set. With `pingpong` low, bank 1's flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_enable | input | 1 | Endpoint enabled |
| ep_configured | input | 1 | Endpoint configured |
| pingpong | input | 1 | 1 = two alternating banks, 0 = bank 0 only |
| rx_valid | input | 1 | Payload byte strobe |
| rx_data | input | 8 | Payload byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_crc_ok | input | 1 | CRC good, sampled with `rx_eop` |
| irq_enable | input | 1 | Interrupt enable |
| sw_sel | input | 1 | Bank seen by the read port and `byte_cnt` |
| sw_read | input | 1 | Advance the selected bank's read pointer |
| sw_clear | input | 2 | Per-bank flag clear pulses |
| rd_data | output | 8 | Byte at the selected bank's read pointer |
| byte_cnt | output | $clog2(DEPTH+1) | Stored byte count of the selected bank |
| rx_flag | output | 2 | Per-bank received flags |
| crc_err | output | 1 | CRC error of the latest stored packet |
| irq | output | 1 | Interrupt request |

## Verification
A wrong active-bank register shows up as a flag on the wrong `rx_flag` bit. It appears in the cycle after the end-of-packet strobe and persists until the next clear. A count that is wrong or fails to saturate appears on `byte_cnt` one cycle after the offending byte. A wrong read pointer changes `rd_data` right after the `sw_read` pulse. The bench's behavioural model is compared against every output on every clock, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

    localparam int DATA_W = 8;
    localparam int NBANK  = 2;

    typedef logic [DATA_W-1:0] byte_t;

    // one cycle of traffic from the serial engine
    typedef struct packed {
        logic  valid;
        logic  eop;
        logic  crc_ok;
        byte_t data;
    } rx_beat_t;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_t;

    function automatic bank_t other_bank(input bank_t b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

endpackage

// File: rtl/iso_rx_bank.sv
module iso_rx_bank
    import iso_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  byte_t                      wr_data,
    input  logic                       clr,
    input  logic                       rd_adv,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output byte_t                      rd_data
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AW    = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    byte_t            mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rp_q;
    logic             room;
    logic             avail;

    assign room  = (cnt_q < FULL);
    assign avail = (rp_q < cnt_q);

    always_ff @(posedge clk) begin
        if (wr_en && room && !clr) begin
            mem[cnt_q[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            rp_q  <= '0;
        end else begin
            if (wr_en && room) begin
                cnt_q <= cnt_q + ONE;
            end
            if (rd_adv && avail) begin
                rp_q <= rp_q + ONE;
            end
        end
    end

    assign cnt     = cnt_q;
    assign rd_data = avail ? mem[rp_q[AW-1:0]] : '0;

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    // R9
    rdptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rp_q <= cnt_q);

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0) && (rp_q == '0));
endmodule

// File: rtl/iso_rx_ctrl.sv
module iso_rx_ctrl
    import iso_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ep_enable,
    input  logic             ep_configured,
    input  logic             pingpong,
    input  rx_beat_t         beat,
    input  logic             irq_enable,
    input  logic [NBANK-1:0] sw_clear,
    output logic [NBANK-1:0] wr_en,
    output logic [NBANK-1:0] flag,
    output logic             crc_err,
    output logic             irq
);
    logic             live;
    logic             target_busy;
    logic             eop_take;
    bank_t            act_q;
    logic [NBANK-1:0] flag_q;
    logic             crc_q;

    assign live        = ep_enable && ep_configured;
    assign target_busy = flag_q[act_q];
    assign eop_take    = live && beat.eop && !target_busy;

    for (genvar b = 0; b < NBANK; b++) begin : g_wr
        assign wr_en[b] = live && beat.valid && !target_busy && (act_q == bank_t'(b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            crc_q  <= 1'b0;
            act_q  <= BANK_A;
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                if (sw_clear[b]) begin
                    flag_q[b] <= 1'b0;
                end else if (eop_take && act_q == bank_t'(b)) begin
                    flag_q[b] <= 1'b1;
                end
            end
            if (eop_take) begin
                crc_q <= !beat.crc_ok;
            end
            if (!pingpong) begin
                act_q <= BANK_A;
            end else if (eop_take) begin
                act_q <= other_bank(act_q);
            end
        end
    end

    assign flag    = flag_q;
    assign crc_err = crc_q;
    assign irq     = irq_enable && (|flag_q);

    for (genvar b = 0; b < NBANK; b++) begin : g_chk
        // R5
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            flag_q[b] && !sw_clear[b] |=> flag_q[b]);

        // R2
        flag_set_src_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_q[b]) |-> $past(beat.eop && live));
    end

    // R1
    gate_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !live && (sw_clear == '0) |=> $stable(flag_q) && $stable(crc_q));

    // R10
    bank1_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pingpong && $past(!pingpong) && !flag_q[1] |=> !flag_q[1]);
endmodule

// File: rtl/iso_out_rxbuf.sv
module iso_out_rxbuf
    import iso_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ep_enable,
    input  logic                       ep_configured,
    input  logic                       pingpong,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_data,
    input  logic                       rx_eop,
    input  logic                       rx_crc_ok,
    input  logic                       irq_enable,
    input  logic                       sw_sel,
    input  logic                       sw_read,
    input  logic [1:0]                 sw_clear,
    output logic [7:0]                 rd_data,
    output logic [$clog2(DEPTH+1)-1:0] byte_cnt,
    output logic [1:0]                 rx_flag,
    output logic                       crc_err,
    output logic                       irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_beat_t         beat;
    logic [NBANK-1:0] wr_en;
    logic [CNT_W-1:0] cnt_a [NBANK];
    byte_t            rdd_a [NBANK];

    assign beat = '{valid: rx_valid, eop: rx_eop, crc_ok: rx_crc_ok, data: rx_data};

    iso_rx_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .ep_enable     (ep_enable),
        .ep_configured (ep_configured),
        .pingpong      (pingpong),
        .beat          (beat),
        .irq_enable    (irq_enable),
        .sw_clear      (sw_clear),
        .wr_en         (wr_en),
        .flag          (rx_flag),
        .crc_err       (crc_err),
        .irq           (irq)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        iso_rx_bank #(.DEPTH(DEPTH)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en[b]),
            .wr_data (beat.data),
            .clr     (sw_clear[b]),
            .rd_adv  (sw_read && (sw_sel == 1'(b))),
            .cnt     (cnt_a[b]),
            .rd_data (rdd_a[b])
        );
    end

    assign byte_cnt = cnt_a[sw_sel];
    assign rd_data  = rdd_a[sw_sel];
endmodule

// File: tb/iso_out_rxbuf_tb.sv
module iso_out_rxbuf_tb;
    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 0;
    logic rst = 1;
    logic ep_enable = 0, ep_configured = 0, pingpong = 0;
    logic rx_valid = 0, rx_eop = 0, rx_crc_ok = 0;
    logic [7:0] rx_data = 0;
    logic irq_enable = 0, sw_sel = 0, sw_read = 0;
    logic [1:0] sw_clear = 0;
    logic [7:0] rd_data;
    logic [CW-1:0] byte_cnt;
    logic [1:0] rx_flag;
    logic crc_err, irq;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    iso_out_rxbuf #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .ep_enable(ep_enable), .ep_configured(ep_configured),
        .pingpong(pingpong), .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop),
        .rx_crc_ok(rx_crc_ok), .irq_enable(irq_enable), .sw_sel(sw_sel),
        .sw_read(sw_read), .sw_clear(sw_clear), .rd_data(rd_data),
        .byte_cnt(byte_cnt), .rx_flag(rx_flag), .crc_err(crc_err), .irq(irq)
    );

    // behavioural reference model
    logic [7:0] mm [2][DEPTH];
    int  mc [2];
    int  mr [2];
    bit  mf [2];
    int  ma;
    bit  mcrc;

    always @(posedge clk) begin
        if (rst) begin
            mc[0] = 0; mc[1] = 0; mr[0] = 0; mr[1] = 0;
            mf[0] = 0; mf[1] = 0; ma = 0; mcrc = 0;
        end else begin
            automatic bit en = ep_enable && ep_configured;
            automatic int s = int'(sw_sel);
            if (sw_read && mr[s] < mc[s]) mr[s]++;
            if (en && rx_valid && !mf[ma] && mc[ma] < DEPTH && !sw_clear[ma]) begin
                mm[ma][mc[ma]] = rx_data;
                mc[ma]++;
            end
            if (en && rx_eop && !mf[ma]) begin
                mf[ma] = 1;
                mcrc = !rx_crc_ok;
                if (pingpong) ma = 1 - ma;
            end
            for (int b = 0; b < 2; b++) begin
                if (sw_clear[b]) begin
                    mf[b] = 0; mc[b] = 0; mr[b] = 0;
                end
            end
            if (!pingpong) ma = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            automatic int s = int'(sw_sel);
            automatic int erd = (mr[s] < mc[s]) ? int'(mm[s][mr[s]]) : 0;
            check("R2 flags", int'(rx_flag), int'({mf[1], mf[0]}));
            check("R10 irq", int'(irq), int'(irq_enable && (mf[0] || mf[1])));
            check("R4 crc_err", int'(crc_err), int'(mcrc));
            check("R3 byte_cnt", int'(byte_cnt), mc[s]);
            check("R9 rd_data", int'(rd_data), erd);
        end
    end

    task automatic drive(input bit v, input logic [7:0] d, input bit e, input bit ok,
                         input logic [1:0] c, input bit r);
        @(posedge clk); #1;
        rx_valid = v; rx_data = d; rx_eop = e; rx_crc_ok = ok; sw_clear = c; sw_read = r;
    endtask

    task automatic idle();
        drive(0, 8'h00, 0, 0, 2'b00, 0);
    endtask

    task automatic settle();
        idle();
        @(negedge clk);
    endtask

    task automatic send_pkt(input int n, input logic [7:0] base, input bit ok);
        for (int i = 0; i < n; i++) drive(1, base + 8'(i), 0, 0, 2'b00, 0);
        drive(0, 8'h00, 1, ok, 2'b00, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        settle();
        check("reset flags", int'(rx_flag), 0);
        check("reset byte_cnt", int'(byte_cnt), 0);

        // R1: gated while not configured
        ep_enable = 1;
        send_pkt(3, 8'h11, 1);
        settle();
        check("R1 flags while unconfigured", int'(rx_flag), 0);
        check("R1 count while unconfigured", int'(byte_cnt), 0);

        // R2/R3/R9/R10: single-bank packet
        ep_configured = 1; irq_enable = 1;
        send_pkt(5, 8'h50, 1);
        settle();
        check("R2 flag bank0", int'(rx_flag), 1);
        check("R10 bank1 idle in single mode", int'(rx_flag[1]), 0);
        check("R10 irq set", int'(irq), 1);
        check("R3 count 5", int'(byte_cnt), 5);
        for (int i = 0; i < 5; i++) begin
            check("R9 read order", int'(rd_data), 8'h50 + i);
            drive(0, 8'h00, 0, 0, 2'b00, 1);
            settle();
        end
        check("R3 empty read gives 0", int'(rd_data), 0);

        // R5: flag set, packet discarded
        send_pkt(4, 8'h70, 0);
        settle();
        check("R5 count kept", int'(byte_cnt), 5);
        check("R5 crc kept", int'(crc_err), 0);

        // R3/R4: zero-length packet with bad CRC
        drive(0, 8'h00, 0, 0, 2'b01, 0);
        send_pkt(0, 8'h00, 0);
        settle();
        check("R3 zlp count", int'(byte_cnt), 0);
        check("R2 zlp flag", int'(rx_flag), 1);
        check("R4 crc bad", int'(crc_err), 1);

        // R6: clear in the middle of a packet
        drive(1, 8'hA0, 0, 0, 2'b00, 0);
        drive(1, 8'hA1, 0, 0, 2'b00, 0);
        drive(1, 8'hAF, 0, 0, 2'b01, 0);
        for (int i = 2; i < 6; i++) drive(1, 8'hA0 + 8'(i), 0, 0, 2'b00, 0);
        drive(0, 8'h00, 1, 1, 2'b00, 0);
        settle();
        check("R6 tail count", int'(byte_cnt), 4);
        check("R6 first kept byte", int'(rd_data), 8'hA2);
        check("R6 crc good", int'(crc_err), 0);

        // R7: overflow
        drive(0, 8'h00, 0, 0, 2'b01, 0);
        send_pkt(DEPTH + 6, 8'h00, 1);
        settle();
        check("R7 saturated count", int'(byte_cnt), DEPTH);
        check("R7 flag after overflow", int'(rx_flag), 1);

        // R8: dual-bank alternation
        drive(0, 8'h00, 0, 0, 2'b01, 0);
        pingpong = 1;
        send_pkt(3, 8'h10, 1);
        settle();
        check("R8 first to bank0", int'(rx_flag), 1);
        send_pkt(2, 8'h20, 0);
        settle();
        check("R8 second to bank1", int'(rx_flag), 3);
        check("R4 crc from bank1 pkt", int'(crc_err), 1);
        send_pkt(4, 8'h30, 1);
        settle();
        check("R8 full bank discards", int'(byte_cnt), 3);
        check("R8 crc unchanged", int'(crc_err), 1);
        drive(0, 8'h00, 0, 0, 2'b01, 0);
        send_pkt(4, 8'h30, 1);
        settle();
        check("R8 third to bank0", int'(rx_flag), 3);
        check("R8 bank0 count", int'(byte_cnt), 4);
        sw_sel = 1;
        settle();
        check("R8 bank1 count", int'(byte_cnt), 2);
        check("R8 bank1 data", int'(rd_data), 8'h20);

        // R10: irq masking and release
        irq_enable = 0;
        settle();
        check("R10 irq masked", int'(irq), 0);
        irq_enable = 1;
        drive(0, 8'h00, 0, 0, 2'b11, 0);
        settle();
        check("R10 irq released", int'(irq), 0);
        check("R6 flags cleared", int'(rx_flag), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule